// File: doc/BRIEF.md
# Terminal Address Latch and Start Gate

This block holds the terminal's five-bit address and its parity bit, and it decides when terminal operation may begin. While master reset is held, the address and parity pins are copied into a six-bit field. That field sits at bits 15:10 of the status register. The initialization loader may then replace the field with the value from its stored image, but only when the lock pin is low.

At the end of loading the block sets the start-execute bit on its own, but only if the whole load was clean. If it does not, the bit stays clear until the host writes it through the register-write port. The host can override a checksum or read-back failure reported by the loader. It cannot override an address parity error. In that case the host must first write a corrected address and parity field. Only then will a start write take effect.

The field is ordered {address[4:0], parity}. Address parity is odd: the six bits must hold an odd number of ones.

Top module: `tsg_start_gate`

## Requirements
- R1: While `mr_i` is high, each clock loads `field_o` with {`pin_addr_i`, `pin_par_i`}, clears `start_o`, and returns the block to the not-ready state.
- R2: A pulse on `img_we_i` while `lock_i` is low and loading is not yet done replaces `field_o` with `img_field_i` one clock later.
- R3: While `lock_i` is high, a pulse on `img_we_i` leaves `field_o` unchanged.
- R4: `par_err_o` is 1 exactly when `field_o` holds an even number of ones. It is updated in the same clock as `field_o`.
- R5: A pulse on `load_done_i` marks loading as done. `start_o` becomes 1 one clock later only if `img_start_i` is 1, `cksum_fail_i` and `mism_fail_i` are 0, and the address parity is correct. Otherwise `start_o` stays 0.
- R6: A host write of the start bit before loading is done has no effect on `start_o`.
- R7: After loading is done and while parity is correct, a host write to the configuration register (address `CFG_ADDR`, default 1) sets `start_o` to data bit `START_BIT` (default 13) one clock later. This holds even if the loader reported a checksum or mismatch failure.
- R8: While `par_err_o` is 1, a host write of 1 to the start bit leaves `start_o` at 0.
- R9: A host write to the status register (address `STAT_ADDR`, default 2) loads `field_o` from data bits 15:10, but only while `start_o` is 0. While `start_o` is 1, such a write leaves `field_o` unchanged.
- R10: Host writes to any address other than `STAT_ADDR` and `CFG_ADDR` change neither `field_o` nor `start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr_i | input | 1 | Master reset, synchronous, active high |
| pin_addr_i | input | 5 | Terminal address pins |
| pin_par_i | input | 1 | Terminal address parity pin |
| lock_i | input | 1 | High keeps the pin values and blocks the image word |
| img_we_i | input | 1 | Loader presents the image's address field |
| img_field_i | input | 6 | Image address field {address, parity} |
| load_done_i | input | 1 | Loading finished (ready rises) |
| img_start_i | input | 1 | Image's start-execute bit |
| cksum_fail_i | input | 1 | Loader checksum failure |
| mism_fail_i | input | 1 | Loader read-back mismatch |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 5 | Host register address |
| host_wdata_i | input | 16 | Host write data |
| field_o | output | 6 | Latched address field {address, parity} |
| par_err_o | output | 1 | Address parity failure |
| start_o | output | 1 | Start-execute bit |

## Verification
Every result is registered, so the field, the parity flag and the start bit all change at the first rising edge after the stimulus that was sampled. The bench drives each stimulus on a falling edge and removes it on the next falling edge, so each pulse lasts exactly one rising edge. It compares the outputs on that same falling edge, which is one clock after the stimulus and half a period after the edge that updated them. For the cases where a stimulus must be ignored (R3, R6, R8, R9 and R10), the bench checks the same outputs at that same point to confirm they kept their previous values.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
    localparam int unsigned TSG_ADDR_PINS = 5;
    localparam int unsigned TSG_REG_AW    = 5;
    localparam int unsigned TSG_DATA_W    = 16;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_STAT = 2'd1,
        TGT_CFG  = 2'd2
    } host_tgt_e;
endpackage

// File: rtl/tsg_oddpar.sv
module tsg_oddpar #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] vec_i,
    output logic         err_o
);
    // odd parity expected: an even count of ones is an error
    always_comb begin
        err_o = ~(^vec_i);
    end
endmodule

// File: rtl/tsg_host_dec.sv
module tsg_host_dec
    import tsg_pkg::*;
#(
    parameter int unsigned AW        = TSG_REG_AW,
    parameter int unsigned DW        = TSG_DATA_W,
    parameter int unsigned FW        = TSG_ADDR_PINS + 1,
    parameter logic [AW-1:0] STAT_ADDR = 5'h02,
    parameter logic [AW-1:0] CFG_ADDR  = 5'h01,
    parameter int unsigned START_BIT = 13
) (
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          fld_we_o,
    output logic [FW-1:0] fld_val_o,
    output logic          start_we_o,
    output logic          start_val_o
);
    localparam int unsigned FLD_LSB = DW - FW;

    host_tgt_e tgt;

    always_comb begin
        tgt = TGT_NONE;
        if (we_i) begin
            if (addr_i == STAT_ADDR)     tgt = TGT_STAT;
            else if (addr_i == CFG_ADDR) tgt = TGT_CFG;
        end
        fld_we_o    = (tgt == TGT_STAT);
        fld_val_o   = wdata_i[DW-1:FLD_LSB];
        start_we_o  = (tgt == TGT_CFG);
        start_val_o = wdata_i[START_BIT];
    end
endmodule

// File: rtl/tsg_start_gate.sv
module tsg_start_gate
    import tsg_pkg::*;
#(
    parameter int unsigned NPIN      = TSG_ADDR_PINS,
    parameter int unsigned AW        = TSG_REG_AW,
    parameter int unsigned DW        = TSG_DATA_W,
    parameter logic [AW-1:0] STAT_ADDR = 5'h02,
    parameter logic [AW-1:0] CFG_ADDR  = 5'h01,
    parameter int unsigned START_BIT = 13
) (
    input  logic            clk,
    input  logic            mr_i,
    input  logic [NPIN-1:0] pin_addr_i,
    input  logic            pin_par_i,
    input  logic            lock_i,
    input  logic            img_we_i,
    input  logic [NPIN:0]   img_field_i,
    input  logic            load_done_i,
    input  logic            img_start_i,
    input  logic            cksum_fail_i,
    input  logic            mism_fail_i,
    input  logic            host_we_i,
    input  logic [AW-1:0]   host_addr_i,
    input  logic [DW-1:0]   host_wdata_i,
    output logic [NPIN:0]   field_o,
    output logic            par_err_o,
    output logic            start_o
);
    localparam int unsigned FW = NPIN + 1;

    typedef struct packed {
        logic [FW-1:0] field;
        logic          par_err;
        logic          start;
        logic          ready;
    } gate_state_t;

    gate_state_t st_d, st_q;

    logic          fld_we;
    logic [FW-1:0] fld_val;
    logic          start_we;
    logic          start_val;
    logic [FW-1:0] field_d;
    logic          perr_d;

    tsg_host_dec #(
        .AW(AW), .DW(DW), .FW(FW),
        .STAT_ADDR(STAT_ADDR), .CFG_ADDR(CFG_ADDR), .START_BIT(START_BIT)
    ) u_dec (
        .we_i       (host_we_i),
        .addr_i     (host_addr_i),
        .wdata_i    (host_wdata_i),
        .fld_we_o   (fld_we),
        .fld_val_o  (fld_val),
        .start_we_o (start_we),
        .start_val_o(start_val)
    );

    // next field value: pins at reset, then image, then host
    always_comb begin
        field_d = st_q.field;
        if (mr_i) begin
            field_d = {pin_addr_i, pin_par_i};
        end else begin
            if (img_we_i && !lock_i && !st_q.ready) field_d = img_field_i;
            if (fld_we && !st_q.start)             field_d = fld_val;
        end
    end

    tsg_oddpar #(.W(FW)) u_par (
        .vec_i(field_d),
        .err_o(perr_d)
    );

    always_comb begin
        st_d         = st_q;
        st_d.field   = field_d;
        st_d.par_err = perr_d;
        if (mr_i) begin
            st_d.start = 1'b0;
            st_d.ready = 1'b0;
        end else if (load_done_i && !st_q.ready) begin
            st_d.ready = 1'b1;
            st_d.start = img_start_i && !cksum_fail_i && !mism_fail_i && !perr_d;
        end else if (start_we && st_q.ready) begin
            // loader errors may be overridden, a parity error may not
            st_d.start = start_val && !perr_d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign field_o   = st_q.field;
    assign par_err_o = st_q.par_err;
    assign start_o   = st_q.start;
endmodule

// File: rtl/tsg_start_gate_chk.sv
module tsg_start_gate_chk #(
    parameter int unsigned NPIN = 5
) (
    input logic            clk,
    input logic            mr_i,
    input logic [NPIN-1:0] pin_addr_i,
    input logic            pin_par_i,
    input logic            lock_i,
    input logic            load_done_i,
    input logic            host_we_i,
    input logic [NPIN:0]   field_o,
    input logic            par_err_o,
    input logic            start_o
);
    AST_RESET_CAPTURE: assert property (@(posedge clk)
        mr_i |=> (field_o == $past({pin_addr_i, pin_par_i})) && !start_o); // R1

    AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (mr_i)
        $changed(field_o) |-> (par_err_o == ($countones(field_o) % 2 == 0))); // R4

    AST_NO_START_ON_PARITY: assert property (@(posedge clk) disable iff (mr_i)
        start_o |-> !par_err_o); // R8

    AST_FIELD_FROZEN: assert property (@(posedge clk) disable iff (mr_i)
        start_o |=> $stable(field_o)); // R9

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (mr_i)
        $rose(start_o) |-> $past(load_done_i || host_we_i)); // R5

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (mr_i)
        (!$past(mr_i) && $past(lock_i) && !$past(host_we_i)) |-> $stable(field_o)); // R3
endmodule

bind tsg_start_gate tsg_start_gate_chk #(.NPIN(NPIN)) u_chk (
    .clk        (clk),
    .mr_i       (mr_i),
    .pin_addr_i (pin_addr_i),
    .pin_par_i  (pin_par_i),
    .lock_i     (lock_i),
    .load_done_i(load_done_i),
    .host_we_i  (host_we_i),
    .field_o    (field_o),
    .par_err_o  (par_err_o),
    .start_o    (start_o)
);

// File: tb/sim_tsg_start_gate.sv
module sim_tsg_start_gate;
    logic        clk = 1'b0;
    logic        mr_i = 1'b1;
    logic [4:0]  pin_addr_i = '0;
    logic        pin_par_i = 1'b0;
    logic        lock_i = 1'b1;
    logic        img_we_i = 1'b0;
    logic [5:0]  img_field_i = '0;
    logic        load_done_i = 1'b0;
    logic        img_start_i = 1'b0;
    logic        cksum_fail_i = 1'b0;
    logic        mism_fail_i = 1'b0;
    logic        host_we_i = 1'b0;
    logic [4:0]  host_addr_i = '0;
    logic [15:0] host_wdata_i = '0;
    logic [5:0]  field_o;
    logic        par_err_o;
    logic        start_o;

    int checks = 0;
    int failures = 0;

    localparam logic [4:0]  A_STAT = 5'h02;
    localparam logic [4:0]  A_CFG  = 5'h01;
    localparam logic [15:0] D_GO   = 16'h2000;

    always #10 clk = ~clk;

    tsg_start_gate u0 (
        .clk(clk), .mr_i(mr_i), .pin_addr_i(pin_addr_i), .pin_par_i(pin_par_i),
        .lock_i(lock_i), .img_we_i(img_we_i), .img_field_i(img_field_i),
        .load_done_i(load_done_i), .img_start_i(img_start_i),
        .cksum_fail_i(cksum_fail_i), .mism_fail_i(mism_fail_i),
        .host_we_i(host_we_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
        .field_o(field_o), .par_err_o(par_err_o), .start_o(start_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] a, input logic p);
        @(negedge clk);
        pin_addr_i = a; pin_par_i = p; mr_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mr_i = 1'b0;
    endtask

    task automatic host_wr(input logic [4:0] addr, input logic [15:0] data);
        @(negedge clk);
        host_we_i = 1'b1; host_addr_i = addr; host_wdata_i = data;
        @(negedge clk);
        host_we_i = 1'b0;
    endtask

    task automatic img_wr(input logic [5:0] f);
        @(negedge clk);
        img_we_i = 1'b1; img_field_i = f;
        @(negedge clk);
        img_we_i = 1'b0;
    endtask

    task automatic finish_load(input logic s, input logic ck, input logic mm);
        @(negedge clk);
        load_done_i = 1'b1; img_start_i = s; cksum_fail_i = ck; mism_fail_i = mm;
        @(negedge clk);
        load_done_i = 1'b0; img_start_i = 1'b0; cksum_fail_i = 1'b0; mism_fail_i = 1'b0;
    endtask

    task automatic t_reset_capture();
        do_reset(5'b10110, 1'b0);
        chk("R1 field after reset", {10'd0, field_o}, 16'h002C);
        chk("R1 start after reset", {15'd0, start_o}, 16'd0);
        chk("R4 parity ok after reset", {15'd0, par_err_o}, 16'd0);
    endtask

    task automatic t_lock_high_auto_start();
        lock_i = 1'b1;
        do_reset(5'b10110, 1'b0);
        img_wr(6'b000000);
        chk("R3 image ignored under lock", {10'd0, field_o}, 16'h002C);
        finish_load(1'b1, 1'b0, 1'b0);
        chk("R5 clean auto start", {15'd0, start_o}, 16'd1);
        host_wr(A_STAT, {6'b000111, 10'd0});
        chk("R9 field frozen while started", {10'd0, field_o}, 16'h002C);
        host_wr(5'h07, 16'h0000);
        chk("R10 other address keeps start", {15'd0, start_o}, 16'd1);
        host_wr(A_CFG, 16'h0000);
        chk("R7 host clears start", {15'd0, start_o}, 16'd0);
        host_wr(A_STAT, {6'b000111, 10'd0});
        chk("R9 field written while stopped", {10'd0, field_o}, 16'h0007);
        host_wr(5'h07, 16'hFC00);
        chk("R10 other address keeps field", {10'd0, field_o}, 16'h0007);
    endtask

    task automatic t_image_parity_block();
        lock_i = 1'b0;
        do_reset(5'b10110, 1'b0);
        img_wr(6'b110000);
        chk("R2 image replaces field", {10'd0, field_o}, 16'h0030);
        chk("R4 even ones flagged", {15'd0, par_err_o}, 16'd1);
        finish_load(1'b1, 1'b0, 1'b0);
        chk("R5 parity blocks auto start", {15'd0, start_o}, 16'd0);
        img_wr(6'b000001);
        chk("R2 image ignored after done", {10'd0, field_o}, 16'h0030);
        host_wr(A_CFG, D_GO);
        chk("R8 host start ignored on parity", {15'd0, start_o}, 16'd0);
        host_wr(A_STAT, {6'b110001, 10'd0});
        chk("R4 corrected parity", {15'd0, par_err_o}, 16'd0);
        host_wr(A_CFG, D_GO);
        chk("R8 start after correction", {15'd0, start_o}, 16'd1);
        lock_i = 1'b1;
    endtask

    task automatic t_loader_error_override();
        do_reset(5'b00001, 1'b0);
        finish_load(1'b1, 1'b1, 1'b0);
        chk("R5 checksum blocks auto start", {15'd0, start_o}, 16'd0);
        host_wr(A_CFG, D_GO);
        chk("R7 override checksum error", {15'd0, start_o}, 16'd1);
        do_reset(5'b00001, 1'b0);
        finish_load(1'b1, 1'b0, 1'b1);
        chk("R5 mismatch blocks auto start", {15'd0, start_o}, 16'd0);
        host_wr(A_CFG, D_GO);
        chk("R7 override mismatch error", {15'd0, start_o}, 16'd1);
        do_reset(5'b00001, 1'b0);
        chk("R1 reset clears start", {15'd0, start_o}, 16'd0);
    endtask

    task automatic t_start_low_and_early();
        do_reset(5'b11100, 1'b0);
        host_wr(A_CFG, D_GO);
        chk("R6 early host start ignored", {15'd0, start_o}, 16'd0);
        finish_load(1'b0, 1'b0, 1'b0);
        chk("R5 image start low", {15'd0, start_o}, 16'd0);
        host_wr(A_CFG, D_GO);
        chk("R7 host start after ready", {15'd0, start_o}, 16'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_capture();
        t_lock_high_auto_start();
        t_image_parity_block();
        t_loader_error_override();
        t_start_low_and_early();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule